// File: doc/BRIEF.md
# NaN-Boxing Operand and Result Unit

This block sits between a 64-bit floating-point register file and a datapath that handles both single-precision (32-bit) and double-precision (64-bit) values. The arithmetic itself is outside the block. The block is purely combinational and adapts register contents on both the read side and the write side.

On the read side, each register operand is tested for a proper box. A 32-bit value is properly boxed when every bit above the low 32 is a one. For single-precision compute work, a boxed operand hands its low 32 bits to the datapath. An unboxed operand is replaced by the single-precision canonical quiet NaN. Transfer work takes the low bits without any test.

On the write side, single-precision results and inbound single-precision transfers (loads, or moves from an integer register) are boxed with ones above bit 31. Outbound single-precision transfers (stores, or moves to an integer register) take only the low 32 bits of operand 0. Double-precision work passes all 64 bits through untouched.

Top module: `nanbox_unit`

## Requirements
- R1: For each operand i, `boxOk[i]` is 1 exactly when bits 63:32 of that operand are all ones, whatever the format and class inputs are.
- R2: With `fmtSel`=0 (single) and `opClass`=0 (compute), a boxed operand i appears on its 64-bit lane of `dpOperand` as `{32'h0, operand[31:0]}`.
- R3: With `fmtSel`=0 and `opClass`=0, an operand whose bits 63:32 are not all ones (even one zero bit) appears on its lane of `dpOperand` as `64'h00000000_7FC00000`.
- R4: With `fmtSel`=0 and `opClass`=0, `rfWriteData` equals `{32'hFFFFFFFF, dpResult[31:0]}`, and the upper bits of `dpResult` have no effect.
- R5: With `fmtSel`=0 and `opClass`=1 (transfer), `rfWriteData` equals `{32'hFFFFFFFF, xferIn[31:0]}`, whatever the low bits hold, including NaN patterns.
- R6: With `fmtSel`=0 and `opClass`=1, each lane of `dpOperand` is `{32'h0, operand[31:0]}` with no box test, so an unboxed operand is not replaced.
- R7: With `fmtSel`=0, `xferOut` equals `{32'h0, operand0[31:0]}`, and bits 63:32 of operand 0 have no effect on it.
- R8: With `fmtSel`=1 (double), every lane of `dpOperand` equals the matching register operand unchanged, for both classes.
- R9: With `fmtSel`=1, `rfWriteData` equals `dpResult` (compute) or `xferIn` (transfer) unchanged, and `xferOut` equals operand 0 unchanged.
- R10: `rfWriteData` is taken from `dpResult` when `opClass`=0 and from `xferIn` when `opClass`=1. The other source has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmtSel | input | 1 | Format select: 0 single, 1 double |
| opClass | input | 1 | Operation class: 0 compute, 1 transfer |
| rfOperand | input | 192 | Three register-file operands, operand i in bits [64i+63:64i] |
| dpOperand | output | 192 | Operands presented to the datapath, same lane layout |
| boxOk | output | 3 | Per-operand box-valid flag |
| dpResult | input | 64 | Result produced by the datapath |
| xferIn | input | 64 | Inbound transfer data (load or move from integer) |
| rfWriteData | output | 64 | Value written to the register file |
| xferOut | output | 64 | Outbound transfer data taken from operand 0 |

## Verification
Operand substitution on the read side and result boxing on the write side act in the same evaluation. A single-precision compute vector can therefore carry unboxed operands while the datapath result has garbage in its upper half. The bench applies such combined vectors. It judges each lane against the canonical NaN or the low bits, and at the same time judges the write data against the boxed low half of the result. Transfer vectors likewise pair an unboxed operand, which must pass through unreplaced, with inbound boxing and outbound extraction.

// File: rtl/nanbox_pkg.sv
package nanbox_pkg;

  typedef enum logic {
    FMT_SINGLE = 1'b0,
    FMT_DOUBLE = 1'b1
  } fmt_e;

  typedef enum logic {
    CLS_COMPUTE  = 1'b0,
    CLS_TRANSFER = 1'b1
  } cls_e;

  // Strobes from control to the datapath halves
  typedef struct packed {
    logic narrow;    // single-precision handling active
    logic checkOps;  // substitute unboxed operands
    logic selXfer;   // write source is the inbound transfer
  } strobe_t;

endpackage

// File: rtl/nanbox_ctrl.sv
module nanbox_ctrl
  import nanbox_pkg::*;
(
  input  logic    fmtSel,
  input  logic    opClass,
  output strobe_t strb
);

  fmt_e fmt;
  cls_e cls;

  always_comb begin
    fmt           = fmt_e'(fmtSel);
    cls           = cls_e'(opClass);
    strb.narrow   = (fmt == FMT_SINGLE);
    strb.checkOps = (fmt == FMT_SINGLE) && (cls == CLS_COMPUTE);
    strb.selXfer  = (cls == CLS_TRANSFER);
  end

endmodule

// File: rtl/nanbox_operand_path.sv
module nanbox_operand_path
  import nanbox_pkg::*;
#(
  parameter int FLEN    = 64,
  parameter int NARROW  = 32,
  parameter int NUM_OPS = 3,
  parameter logic [NARROW-1:0] QNAN = 32'h7FC00000
) (
  input  strobe_t                   strb,
  input  logic [NUM_OPS*FLEN-1:0]   rfOps,
  output logic [NUM_OPS*FLEN-1:0]   dpOps,
  output logic [NUM_OPS-1:0]        boxOk
);

  localparam int BOX_W = FLEN - NARROW;

  for (genvar lane = 0; lane < NUM_OPS; lane++) begin : g_lane
    logic [FLEN-1:0]   full;
    logic [BOX_W-1:0]  upper;
    logic [NARROW-1:0] lowVal;
    logic [NARROW-1:0] narrowVal;

    assign full   = rfOps[lane*FLEN +: FLEN];
    assign upper  = full[FLEN-1:NARROW];
    assign lowVal = full[NARROW-1:0];
    assign boxOk[lane] = &upper;

    always_comb begin
      narrowVal = lowVal;
      if (strb.checkOps && !boxOk[lane]) narrowVal = QNAN;
      if (strb.narrow)
        dpOps[lane*FLEN +: FLEN] = {{BOX_W{1'b0}}, narrowVal};
      else
        dpOps[lane*FLEN +: FLEN] = full;
    end
  end

endmodule

// File: rtl/nanbox_result_path.sv
module nanbox_result_path
  import nanbox_pkg::*;
#(
  parameter int FLEN   = 64,
  parameter int NARROW = 32
) (
  input  strobe_t          strb,
  input  logic [FLEN-1:0]  dpResult,
  input  logic [FLEN-1:0]  xferIn,
  input  logic [FLEN-1:0]  rfOp0,
  output logic [FLEN-1:0]  rfWrData,
  output logic [FLEN-1:0]  xferOut
);

  localparam int BOX_W = FLEN - NARROW;

  logic [FLEN-1:0] wrSrc;

  always_comb begin
    wrSrc = strb.selXfer ? xferIn : dpResult;
    if (strb.narrow) begin
      rfWrData = {{BOX_W{1'b1}}, wrSrc[NARROW-1:0]};
      xferOut  = {{BOX_W{1'b0}}, rfOp0[NARROW-1:0]};
    end else begin
      rfWrData = wrSrc;
      xferOut  = rfOp0;
    end
  end

endmodule

// File: rtl/nanbox_unit.sv
module nanbox_unit
  import nanbox_pkg::*;
#(
  parameter int FLEN    = 64,
  parameter int NARROW  = 32,
  parameter int NUM_OPS = 3,
  parameter logic [NARROW-1:0] QNAN = 32'h7FC00000
) (
  input  logic                     fmtSel,
  input  logic                     opClass,
  input  logic [NUM_OPS*FLEN-1:0]  rfOperand,
  output logic [NUM_OPS*FLEN-1:0]  dpOperand,
  output logic [NUM_OPS-1:0]       boxOk,
  input  logic [FLEN-1:0]          dpResult,
  input  logic [FLEN-1:0]          xferIn,
  output logic [FLEN-1:0]          rfWriteData,
  output logic [FLEN-1:0]          xferOut
);

  localparam int BOX_W = FLEN - NARROW;

  strobe_t strb;

  nanbox_ctrl u_ctrl (
    .fmtSel  (fmtSel),
    .opClass (opClass),
    .strb    (strb)
  );

  nanbox_operand_path #(
    .FLEN(FLEN), .NARROW(NARROW), .NUM_OPS(NUM_OPS), .QNAN(QNAN)
  ) u_opPath (
    .strb  (strb),
    .rfOps (rfOperand),
    .dpOps (dpOperand),
    .boxOk (boxOk)
  );

  nanbox_result_path #(
    .FLEN(FLEN), .NARROW(NARROW)
  ) u_resPath (
    .strb     (strb),
    .dpResult (dpResult),
    .xferIn   (xferIn),
    .rfOp0    (rfOperand[FLEN-1:0]),
    .rfWrData (rfWriteData),
    .xferOut  (xferOut)
  );

  // Port-level checks, one group per lane
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_chk
    always_comb begin
      a_r1_box_flag: assert (boxOk[g] == (rfOperand[g*FLEN+NARROW +: BOX_W] == {BOX_W{1'b1}}))
        else $error("R1 box flag mismatch lane %0d", g);
      if (!fmtSel && !opClass && !boxOk[g]) begin
        a_r3_canon_sub: assert (dpOperand[g*FLEN +: FLEN] == {{BOX_W{1'b0}}, QNAN})
          else $error("R3 unboxed operand not replaced lane %0d", g);
      end
      if (!fmtSel && opClass) begin
        a_r6_xfer_raw: assert (dpOperand[g*FLEN +: NARROW] == rfOperand[g*FLEN +: NARROW])
          else $error("R6 transfer operand altered lane %0d", g);
      end
      if (fmtSel) begin
        a_r8_double_pass: assert (dpOperand[g*FLEN +: FLEN] == rfOperand[g*FLEN +: FLEN])
          else $error("R8 double operand altered lane %0d", g);
      end
    end
  end

  always_comb begin
    if (!fmtSel) begin
      a_r4_upper_ones: assert (rfWriteData[FLEN-1:NARROW] == {BOX_W{1'b1}})
        else $error("R4 narrow write not boxed");
      a_r7_out_low: assert (xferOut == {{BOX_W{1'b0}}, rfOperand[NARROW-1:0]})
        else $error("R7 outbound extract wrong");
    end else begin
      a_r9_out_full: assert (xferOut == rfOperand[FLEN-1:0])
        else $error("R9 outbound double altered");
    end
  end

endmodule

// File: tb/nanbox_unit_tb.sv
`timescale 1ns/1ps
module nanbox_unit_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         fmtSel;
  logic         opClass;
  logic [191:0] rfOperand;
  logic [191:0] dpOperand;
  logic [2:0]   boxOk;
  logic [63:0]  dpResult;
  logic [63:0]  xferIn;
  logic [63:0]  rfWriteData;
  logic [63:0]  xferOut;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  localparam logic [63:0] CANON = 64'h00000000_7FC00000;
  localparam logic [63:0] GOOD1 = 64'hFFFFFFFF_3F800000;
  localparam logic [63:0] GOOD2 = 64'hFFFFFFFF_C0490FDB;
  localparam logic [63:0] BAD0  = 64'h00000000_40000000;
  localparam logic [63:0] BAD1  = 64'hFFFFFFFE_12345678;
  localparam logic [63:0] BAD2  = 64'h7FFFFFFF_AAAA5555;
  localparam logic [63:0] DBL   = 64'h400921FB_54442D18;

  always #5 clk = ~clk;

  nanbox_unit u_dut (
    .fmtSel      (fmtSel),
    .opClass     (opClass),
    .rfOperand   (rfOperand),
    .dpOperand   (dpOperand),
    .boxOk       (boxOk),
    .dpResult    (dpResult),
    .xferIn      (xferIn),
    .rfWriteData (rfWriteData),
    .xferOut     (xferOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic c, input logic [63:0] o0,
                       input logic [63:0] o1, input logic [63:0] o2,
                       input logic [63:0] res, input logic [63:0] xin);
    @(negedge clk);
    fmtSel = f; opClass = c;
    rfOperand = {o2, o1, o0};
    dpResult = res; xferIn = xin;
    #2;
  endtask

  function automatic logic [63:0] lane(input int i);
    return dpOperand[i*64 +: 64];
  endfunction

  task automatic t_reset_state();
    // all-zero inputs: single compute, every operand unboxed
    chk("R1 reset boxOk", {61'h0, boxOk}, 64'h0);
    chk("R3 reset lane0", lane(0), CANON);
    chk("R4 reset write", rfWriteData, 64'hFFFFFFFF_00000000);
  endtask

  task automatic t_detect();
    drive(1'b1, 1'b1, GOOD1, BAD1, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 64'h0);
    chk("R1 detect double/xfer", {61'h0, boxOk}, 64'h5);
    drive(1'b0, 1'b0, BAD2, GOOD2, BAD0, 64'h0, 64'h0);
    chk("R1 detect single/compute", {61'h0, boxOk}, 64'h2);
  endtask

  task automatic t_compute_valid();
    drive(1'b0, 1'b0, GOOD1, GOOD2, 64'hFFFFFFFF_7F800000, 64'h0, 64'h0);
    chk("R2 lane0", lane(0), 64'h00000000_3F800000);
    chk("R2 lane1", lane(1), 64'h00000000_C0490FDB);
    chk("R2 lane2", lane(2), 64'h00000000_7F800000);
  endtask

  task automatic t_compute_bad();
    drive(1'b0, 1'b0, BAD0, BAD1, BAD2, 64'h0, 64'h0);
    chk("R3 zero upper", lane(0), CANON);
    chk("R3 one bit short", lane(1), CANON);
    chk("R3 top bit clear", lane(2), CANON);
  endtask

  task automatic t_concurrent();
    // bad operand substitution and result boxing in the same vector
    drive(1'b0, 1'b0, GOOD1, BAD1, GOOD2, 64'h12345678_40490FDB, 64'hDEADBEEF_CAFEF00D);
    chk("R2 concurrent lane0", lane(0), 64'h00000000_3F800000);
    chk("R3 concurrent lane1", lane(1), CANON);
    chk("R4 concurrent write", rfWriteData, 64'hFFFFFFFF_40490FDB);
    chk("R7 concurrent out", xferOut, 64'h00000000_3F800000);
  endtask

  task automatic t_transfer();
    drive(1'b0, 1'b1, BAD2, BAD0, GOOD1, 64'hAAAAAAAA_11111111, 64'h00000000_7FC00001);
    chk("R5 inbound box", rfWriteData, 64'hFFFFFFFF_7FC00001);
    chk("R6 raw lane0", lane(0), 64'h00000000_AAAA5555);
    chk("R6 raw lane1", lane(1), 64'h00000000_40000000);
    chk("R7 outbound", xferOut, 64'h00000000_AAAA5555);
    drive(1'b0, 1'b1, BAD1, BAD0, BAD0, 64'h0, 64'h55555555_00000000);
    chk("R5 inbound zero low", rfWriteData, 64'hFFFFFFFF_00000000);
    chk("R7 outbound unboxed upper", xferOut, 64'h00000000_12345678);
  endtask

  task automatic t_double();
    drive(1'b1, 1'b0, DBL, BAD0, GOOD1, 64'h3FF00000_00000000, 64'h1);
    chk("R8 compute lane0", lane(0), DBL);
    chk("R8 compute lane1", lane(1), BAD0);
    chk("R9 compute write", rfWriteData, 64'h3FF00000_00000000);
    chk("R9 compute out", xferOut, DBL);
    drive(1'b1, 1'b1, BAD2, DBL, BAD1, 64'h1, 64'h00000000_3F800000);
    chk("R8 xfer lane2", lane(2), BAD1);
    chk("R9 xfer write", rfWriteData, 64'h00000000_3F800000);
    chk("R9 xfer out", xferOut, BAD2);
  endtask

  task automatic t_source_select();
    drive(1'b0, 1'b0, GOOD1, GOOD1, GOOD1, 64'h0_0000ABCD, 64'h0_0000FFFF);
    chk("R10 compute picks result", rfWriteData, 64'hFFFFFFFF_0000ABCD);
    drive(1'b0, 1'b1, GOOD1, GOOD1, GOOD1, 64'h0_0000ABCD, 64'h0_0000FFFF);
    chk("R10 transfer picks inbound", rfWriteData, 64'hFFFFFFFF_0000FFFF);
    drive(1'b1, 1'b1, GOOD1, GOOD1, GOOD1, 64'h0_0000ABCD, 64'h0_0000FFFF);
    chk("R10 double transfer", rfWriteData, 64'h00000000_0000FFFF);
  endtask

  initial begin
    fmtSel = 1'b0; opClass = 1'b0;
    rfOperand = '0; dpResult = '0; xferIn = '0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    t_reset_state();
    t_detect();
    t_compute_valid();
    t_compute_bad();
    t_concurrent();
    t_transfer();
    t_double();
    t_source_select();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule